// File: doc/BRIEF.md
# Flash Bit-7 Polling Completion Checker

This block sits on the host side of a parallel flash and decides whether a program or erase that has already been launched is finished. A start request gives it a status address (the programmed location, or any location inside a sector being erased), the operation type and the data that was written. The block then reads that address over and over through a one-outstanding read request/response port and judges the returned status byte. Bit 7 is compared with the value it will carry once the operation is over. Bit 5 reports that the device has exceeded its internal time limit.

When bit 7 agrees, the block issues one further read, because the low bits of the word that first shows agreement may still be stale. It then reports pass and presents that later word. When bit 5 is set while bit 7 still disagrees, the block takes one confirming read, since bit 7 may settle in the same instant that bit 5 rises. Only a confirming read that still disagrees is a failure. An optional read limit ends a poll that never resolves. The result is a one-cycle done pulse together with exactly one of pass or fail.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset the block is idle: busy_o, rd_req_valid_o, done_o, pass_o and fail_o are all 0.
- R2: Every read request carries the address given with the accepted start, and that address and rd_req_valid_o stay unchanged while rd_req_ready_i is low.
- R3: The target value for bit 7 is 1 when op_erase_i is 1 at start, and exp_data_i[7] when op_erase_i is 0.
- R4: A polling read whose bit 7 equals the target leads to exactly one more read; its full word appears on final_data_o with pass.
- R5: A polling read whose bit 7 differs from the target while bit 5 is 0 leads to another polling read.
- R6: A polling read whose bit 7 differs while bit 5 is 1 leads to one confirming read. If its bit 7 equals the target, one final read follows and the result is pass. If not, the result is fail with the confirming word on final_data_o.
- R7: With the read limit enabled, the WDOG_MAX-th polling read ends in fail if its bit 7 differs and its bit 5 is 0, with that word on final_data_o. If bit 5 is 1 on that read, the confirming read is taken instead.
- R8: done_o is high for one cycle, in the cycle after the response beat that decides the result, and exactly one of pass_o and fail_o is high with it and never without it.
- R9: start_i while the block is busy has no effect on the request address, the target value or the sequence.
- R10: Only one read is outstanding at a time. No new request is raised until rd_rsp_valid_i has returned the previous one, and returned data is judged only on a beat with rd_rsp_valid_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a completion check (taken only when idle) |
| op_erase_i | input | 1 | 1: erase check (target bit 7 = 1), 0: program check |
| addr_i | input | ADDR_W | Status address to poll |
| exp_data_i | input | DATA_W | Data that was programmed |
| busy_o | output | 1 | A check is in progress |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | ADDR_W | Read request address |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_data_i | input | DATA_W | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation completed successfully (with done_o) |
| fail_o | output | 1 | Operation failed (with done_o) |
| final_data_o | output | DATA_W | Word captured with the last result |

## Verification
Two decisions can fall on the same read beat. Bit 5 rising together with bit 7 either agreeing or disagreeing, and bit 5 rising on exactly the polling read that reaches the read limit. The bench drives both on purpose with scripted status words, and adds a random mix in which bit 5 is set on about one read in eight. For each case a bench reference walk of the script predicts the read count, verdict and captured word. That walk gives bit 7 agreement priority over bit 5, and bit 5 priority over the read limit.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } poll_state_e;

   typedef enum logic [1:0] {
      PH_POLL    = 2'd0,
      PH_CONFIRM = 2'd1,
      PH_FINAL   = 2'd2
   } poll_phase_e;

   typedef struct packed {
      logic agree;    // status bit 7 equals target
      logic expired;  // device time-limit flag (bit 5)
   } poll_eval_t;

endpackage

// File: rtl/flash_poll_eval.sv
module flash_poll_eval
   import flash_poll_pkg::*;
#(
   parameter bit INVERT_TMO = 1'b0
) (
   input  logic       st7_i,
   input  logic       st5_i,
   input  logic       target7_i,
   output poll_eval_t eval_o
);

   logic tmo_raw;

   generate
      if (INVERT_TMO) begin : g_tmo_low
         assign tmo_raw = ~st5_i;
      end else begin : g_tmo_high
         assign tmo_raw = st5_i;
      end
   endgenerate

   always_comb begin
      eval_o.agree   = (st7_i == target7_i);
      eval_o.expired = tmo_raw;
   end

endmodule

// File: rtl/flash_poll_wdog.sv
module flash_poll_wdog #(
   parameter bit WDOG_EN  = 1'b1,
   parameter int WDOG_MAX = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic inc_i,
   output logic expire_o
);

   localparam int CNT_W = (WDOG_MAX < 2) ? 1 : $clog2(WDOG_MAX + 1);

   generate
      if (WDOG_EN) begin : g_limit
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)        cnt_q <= '0;
            else if (clear_i)  cnt_q <= '0;
            else if (inc_i && (cnt_q != CNT_W'(WDOG_MAX))) cnt_q <= cnt_q + 1'b1;
         end

         // current beat is the WDOG_MAX-th polling read
         assign expire_o = (cnt_q == CNT_W'(WDOG_MAX - 1));

         assert_wdog_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_W'(WDOG_MAX));
         assert_wdog_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            clear_i |=> (cnt_q == '0));
      end else begin : g_nolimit
         logic unused_wd;
         assign unused_wd = ^{clk, rst_n, clear_i, inc_i};
         assign expire_o  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/flash_poll_fsm.sv
module flash_poll_fsm
   import flash_poll_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       req_ready_i,
   input  logic       rsp_valid_i,
   input  poll_eval_t eval_i,
   input  logic       wd_expire_i,
   output logic       busy_o,
   output logic       req_valid_o,
   output logic       load_o,
   output logic       poll_beat_o,
   output logic       capture_o,
   output logic       done_o,
   output logic       pass_o,
   output logic       fail_o
);

   poll_state_e state_q, state_d;
   poll_phase_e phase_q, phase_d;
   logic        fin_pass, fin_fail;
   logic        rsp_take;

   assign rsp_take = (state_q == ST_WAIT) && rsp_valid_i;

   always_comb begin
      state_d  = state_q;
      phase_d  = phase_q;
      fin_pass = 1'b0;
      fin_fail = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d = ST_REQ;
               phase_d = PH_POLL;
            end
         end
         ST_REQ: begin
            if (req_ready_i) state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (rsp_valid_i) begin
               unique case (phase_q)
                  PH_POLL: begin
                     if (eval_i.agree) begin
                        phase_d = PH_FINAL;
                        state_d = ST_REQ;
                     end else if (eval_i.expired) begin
                        phase_d = PH_CONFIRM;
                        state_d = ST_REQ;
                     end else if (wd_expire_i) begin
                        fin_fail = 1'b1;
                        state_d  = ST_IDLE;
                     end else begin
                        state_d = ST_REQ;
                     end
                  end
                  PH_CONFIRM: begin
                     if (eval_i.agree) begin
                        phase_d = PH_FINAL;
                        state_d = ST_REQ;
                     end else begin
                        fin_fail = 1'b1;
                        state_d  = ST_IDLE;
                     end
                  end
                  default: begin
                     fin_pass = 1'b1;
                     state_d  = ST_IDLE;
                  end
               endcase
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_POLL;
         done_o  <= 1'b0;
         pass_o  <= 1'b0;
         fail_o  <= 1'b0;
      end else begin
         state_q <= state_d;
         phase_q <= phase_d;
         done_o  <= fin_pass | fin_fail;
         pass_o  <= fin_pass;
         fail_o  <= fin_fail;
      end
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign req_valid_o = (state_q == ST_REQ);
   assign load_o      = (state_q == ST_IDLE) && start_i;
   assign poll_beat_o = rsp_take && (phase_q == PH_POLL);
   assign capture_o   = fin_pass | fin_fail;

   assert_result_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_o | fail_o) |-> (done_o && (pass_o ^ fail_o)));
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_done_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(rsp_valid_i));
   assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && req_ready_i) |=> !req_valid_o);
   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_o && !req_ready_i) |=> req_valid_o);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !req_valid_o);

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
   import flash_poll_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int DATA_W   = 8,
   parameter bit WDOG_EN  = 1'b1,
   parameter int WDOG_MAX = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              op_erase_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] exp_data_i,
   output logic              busy_o,
   output logic              rd_req_valid_o,
   input  logic              rd_req_ready_i,
   output logic [ADDR_W-1:0] rd_req_addr_o,
   input  logic              rd_rsp_valid_i,
   input  logic [DATA_W-1:0] rd_rsp_data_i,
   output logic              done_o,
   output logic              pass_o,
   output logic              fail_o,
   output logic [DATA_W-1:0] final_data_o
);

   localparam int ST7_POS = 7;
   localparam int ST5_POS = 5;

   generate
      if (DATA_W < 8) begin : g_chk_width
         $error("flash_poll_ctrl: DATA_W must be at least 8");
      end
      if (ADDR_W < 1) begin : g_chk_addr
         $error("flash_poll_ctrl: ADDR_W must be at least 1");
      end
      if (WDOG_EN && (WDOG_MAX < 1)) begin : g_chk_wdog
         $error("flash_poll_ctrl: WDOG_MAX must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic              target7_q;
   logic [DATA_W-1:0] data_q;
   logic              load, poll_beat, capture, wd_expire;
   poll_eval_t        eval;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q    <= '0;
         target7_q <= 1'b0;
         data_q    <= '0;
      end else begin
         if (load) begin
            addr_q    <= addr_i;
            target7_q <= op_erase_i ? 1'b1 : exp_data_i[ST7_POS];
         end
         if (capture) data_q <= rd_rsp_data_i;
      end
   end

   flash_poll_eval #(
      .INVERT_TMO(1'b0)
   ) u_eval (
      .st7_i    (rd_rsp_data_i[ST7_POS]),
      .st5_i    (rd_rsp_data_i[ST5_POS]),
      .target7_i(target7_q),
      .eval_o   (eval)
   );

   flash_poll_wdog #(
      .WDOG_EN (WDOG_EN),
      .WDOG_MAX(WDOG_MAX)
   ) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (load),
      .inc_i   (poll_beat),
      .expire_o(wd_expire)
   );

   flash_poll_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .req_ready_i(rd_req_ready_i),
      .rsp_valid_i(rd_rsp_valid_i),
      .eval_i     (eval),
      .wd_expire_i(wd_expire),
      .busy_o     (busy_o),
      .req_valid_o(rd_req_valid_o),
      .load_o     (load),
      .poll_beat_o(poll_beat),
      .capture_o  (capture),
      .done_o     (done_o),
      .pass_o     (pass_o),
      .fail_o     (fail_o)
   );

   assign rd_req_addr_o = addr_q;
   assign final_data_o  = data_q;

   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_valid_o && !rd_req_ready_i) |=> $stable(rd_req_addr_o));
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(rd_req_addr_o) && $stable(target7_q)));
   assert_target_erase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && op_erase_i) |=> target7_q);
   assert_data_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (final_data_o == $past(rd_rsp_data_i)));

endmodule

// File: tb/flash_poll_ctrl_tb.sv
`timescale 1ns/1ps
module flash_poll_ctrl_tb;

   localparam int AW   = 20;
   localparam int DW   = 8;
   localparam int WMAX = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          op_erase_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] exp_data_i = '0;
   logic          busy_o, rd_req_valid_o, rd_req_ready_i = 1'b0;
   logic [AW-1:0] rd_req_addr_o;
   logic          rd_rsp_valid_i = 1'b0;
   logic [DW-1:0] rd_rsp_data_i = '0;
   logic          done_o, pass_o, fail_o;
   logic [DW-1:0] final_data_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [7:0] scr [0:15];

   always #2 clk = ~clk;

   flash_poll_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .WDOG_EN(1'b1), .WDOG_MAX(WMAX)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
      .addr_i(addr_i), .exp_data_i(exp_data_i), .busy_o(busy_o),
      .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i),
      .rd_req_addr_o(rd_req_addr_o), .rd_rsp_valid_i(rd_rsp_valid_i),
      .rd_rsp_data_i(rd_rsp_data_i), .done_o(done_o), .pass_o(pass_o),
      .fail_o(fail_o), .final_data_o(final_data_o)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung (actual cycles %0d, expected < 150000)", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference walk of the script: bit7 agreement first, then bit5, then limit
   function automatic void predict(input bit t7, output bit pass, output int nreads,
                                   output logic [7:0] fdata);
      int ph = 0;  // 0 poll, 1 confirm, 2 final
      int polls = 0;
      pass = 1'b0; nreads = 0; fdata = '0;
      for (int i = 0; i < 16; i++) begin
         logic [7:0] d = scr[i];
         nreads = i + 1;
         if (ph == 2) begin pass = 1'b1; fdata = d; return; end
         if (ph == 1) begin
            if (d[7] == t7) ph = 2;
            else begin fdata = d; return; end
         end else begin
            polls++;
            if (d[7] == t7) ph = 2;
            else if (d[5]) ph = 1;
            else if (polls >= WMAX) begin fdata = d; return; end
         end
      end
   endfunction

   task automatic run_op(input string tag, input bit erase, input logic [AW-1:0] a,
                         input logic [7:0] ex, input bit poke);
      bit t7, exp_pass, bad_addr, got_done;
      int exp_n, n;
      logic [7:0] exp_d;
      t7 = erase ? 1'b1 : ex[7];
      predict(t7, exp_pass, exp_n, exp_d);
      @(negedge clk);
      start_i = 1'b1; op_erase_i = erase; addr_i = a; exp_data_i = ex;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R9", {tag, " busy after start"}, busy_o, 1);
      n = 0; bad_addr = 1'b0; got_done = 1'b0;
      while (!got_done) begin
         while (!rd_req_valid_o && !done_o) @(negedge clk);
         if (done_o) begin
            got_done = 1'b1;
         end else begin
            if (poke && n == 0) begin
               start_i = 1'b1; addr_i = ~a; op_erase_i = ~erase; exp_data_i = ~ex;
            end
            repeat ($urandom % 3) begin
               @(negedge clk);
               if (rd_req_addr_o != a || !rd_req_valid_o) bad_addr = 1'b1;
            end
            start_i = 1'b0;
            if (rd_req_addr_o != a) bad_addr = 1'b1;
            rd_req_ready_i = 1'b1;
            @(negedge clk);
            rd_req_ready_i = 1'b0;
            repeat ($urandom % 3) begin
               @(negedge clk);
               if (rd_req_valid_o) bad_addr = 1'b1;
            end
            rd_rsp_valid_i = 1'b1;
            rd_rsp_data_i = scr[n];
            @(negedge clk);
            rd_rsp_valid_i = 1'b0;
            rd_rsp_data_i = $urandom;
            n++;
         end
      end
      check(!bad_addr, "R2/R10", {tag, " request address and single outstanding"}, bad_addr, 0);
      check(n == exp_n, "R5/R6", {tag, " read count"}, n, exp_n);
      check(pass_o == exp_pass && fail_o == !exp_pass, exp_pass ? "R4" : "R6/R7",
            {tag, " verdict pass"}, pass_o, exp_pass);
      check(final_data_o == exp_d, "R4", {tag, " final word"}, final_data_o, exp_d);
      @(negedge clk);
      check(!done_o && !pass_o && !fail_o && !busy_o, "R8", {tag, " one-cycle done"},
            {done_o, pass_o, fail_o, busy_o}, 0);
   endtask

   function automatic logic [7:0] mk(input bit b7, input bit b5);
      logic [7:0] w = 8'($urandom);
      w[7] = b7; w[5] = b5;
      return w;
   endfunction

   initial begin
      void'($urandom(32'h1f2e3d4c));
      repeat (3) @(negedge clk);
      check(!busy_o && !rd_req_valid_o && !done_o && !pass_o && !fail_o, "R1",
            "reset state", {busy_o, rd_req_valid_o, done_o, pass_o, fail_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: immediate agreement on program, target from exp_data bit7 (R3)
      scr[0] = mk(1, 0); scr[1] = 8'hA5;
      run_op("r4_immediate", 1'b0, 20'h12345, 8'h80, 1'b0);
      // R5: several disagreeing polls, then agreement; start poked while busy (R9)
      scr[0] = mk(1, 0); scr[1] = mk(1, 0); scr[2] = mk(0, 0); scr[3] = 8'h3C;
      run_op("r5_r9_repoll", 1'b0, 20'h0ABCD, 8'h05, 1'b1);
      // R6: bit5 then confirming read agrees
      scr[0] = mk(0, 0); scr[1] = mk(0, 1); scr[2] = mk(1, 1); scr[3] = 8'h81;
      run_op("r6_confirm_pass", 1'b1, 20'h00010, 8'h00, 1'b0);
      // R6: bit5 then confirming read still disagrees
      scr[0] = mk(0, 1); scr[1] = mk(0, 1); scr[2] = 8'hFF;
      run_op("r6_confirm_fail", 1'b1, 20'h00020, 8'h00, 1'b0);
      // bit7 agrees on the same read that raises bit5
      scr[0] = mk(0, 1); scr[1] = 8'h42;
      run_op("r6_same_beat", 1'b0, 20'h00030, 8'h11, 1'b0);
      // R7: limit reached
      for (int i = 0; i < 16; i++) scr[i] = mk(0, 0);
      run_op("r7_limit", 1'b0, 20'hFFFFF, 8'h9A, 1'b0);
      // R7: bit5 on the limit read takes the confirming read
      for (int i = 0; i < WMAX - 1; i++) scr[i] = mk(1, 0);
      scr[WMAX-1] = mk(1, 1); scr[WMAX] = mk(0, 0); scr[WMAX+1] = 8'h77;
      run_op("r7_limit_bit5", 1'b0, 20'h55555, 8'h00, 1'b0);
      // R3: erase target is 1 regardless of exp_data bit7
      scr[0] = mk(0, 0); scr[1] = mk(1, 0); scr[2] = 8'h13;
      run_op("r3_erase", 1'b1, 20'h00700, 8'h00, 1'b0);

      for (int k = 0; k < 40; k++) begin
         bit er = 1'($urandom);
         logic [7:0] ex = 8'($urandom);
         bit t7 = er ? 1'b1 : ex[7];
         for (int i = 0; i < 16; i++) begin
            bit agree = (($urandom % 4) == 0);
            scr[i] = mk(agree ? t7 : ~t7, (($urandom % 8) == 0));
         end
         run_op("random", er, 20'($urandom), ex, (k % 7) == 3);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule